// File: doc/BRIEF.md
# Time-Slotted Memory Round Arbiter

This block shares one SRAM among four logical bus devices: two network inputs, a network output and the processor. Time is cut into a fixed, repeating round of eight clocks. The round holds four access slots of two clocks each, and every device owns one of them. The slot order is network input 0, network input 1, network output, then processor. A free-running counter that starts at slot 0 after reset walks this order.

The network interfaces share one want-bus line and a two-bit word-enable field. An interface that raises want-bus at the first clock of its own slot always gets that slot, and the word-enable bits pass through as the SRAM write strobes. If no interface asks for a network slot, a pending processor memory reference takes it. The processor can therefore get two accesses in one round. The processor slot belongs to the processor alone. In that slot the processor may address a register in a network interface instead of memory. It does so on separate select and write lines, and the SRAM stays idle. Every grant is decided at the first clock of a slot and held through the second clock. The processor acknowledge is raised in that second clock.

Top module: `mem_round_arbiter`

## Requirements
- R1: While rst_n is low, grant, sram_ce, sram_wen, nif_sel, nif_wr, cpu_ack and slot_first are all 0. The first clock after reset is released is the first clock of slot 0.
- R2: slot advances every two clocks in the order 0, 1, 2, 3 and then wraps, so a round lasts 8 clocks. slot_first is 1 on the first clock of each slot and 0 on the second.
- R3: If want_bus is 1 at the first clock of network slot s (s = 0 input 0, 1 input 1, 2 output), the following hold for both clocks of that slot: grant equals bit s alone, sram_ce is 1, and sram_wen equals the net_we value seen at that first clock. The processor is not granted, even when cpu_req is 1.
- R4: want_bus is looked at only on the first clock of a slot. A request raised only on the second clock does not change that slot's grant.
- R5: In a network slot whose want_bus is 0 at the first clock, a processor memory reference (cpu_req=1, cpu_to_nif=0) is granted on grant bit 3 with sram_ce=1. sram_wen is cpu_be when cpu_we=1 and 0 when cpu_we=0.
- R6: In slot 3, a pending processor reference is always granted, whatever want_bus is. grant bits 0 to 2 are never set in slot 3.
- R7: A processor reference with cpu_to_nif=1 in slot 3 sets nif_sel to the single bit cpu_nif_idx (0..2) and sets nif_wr to cpu_we, for both clocks. sram_ce and sram_wen stay 0.
- R8: A processor reference with cpu_to_nif=1 gets nothing in a network slot that no interface requests: grant, sram_ce and nif_sel stay 0.
- R9: A slot with no request from its owner and no usable processor request is idle: grant, sram_ce and sram_wen are 0.
- R10: cpu_ack is 1 exactly on the second clock of a slot granted to the processor, so two acks can fall in one round.
- R11: All slot outputs keep the values decided at the first clock through the second clock, whatever the inputs do on that second clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Network clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| want_bus | input | 1 | Shared network request line |
| net_we | input | 2 | Word write enables of the requesting network interface |
| cpu_req | input | 1 | Processor reference pending |
| cpu_we | input | 1 | Processor reference is a write |
| cpu_be | input | 2 | Processor word enables |
| cpu_to_nif | input | 1 | Processor reference targets a network interface register |
| cpu_nif_idx | input | 2 | Target interface for such a reference (0..2) |
| slot | output | 2 | Current slot index |
| slot_first | output | 1 | First clock of the current slot |
| grant | output | 4 | One-hot owner of the current access (bit 3 processor) |
| sram_ce | output | 1 | SRAM chip enable |
| sram_wen | output | 2 | SRAM word write strobes |
| nif_sel | output | 3 | Processor select to a network interface |
| nif_wr | output | 1 | Processor write to the selected interface |
| cpu_ack | output | 1 | Processor reference completes |

## Verification
On every cycle the assertions check four things. The slot counter advances correctly, grant is at most one-hot, and a granted access stays stable across its second clock. A network grant always follows a want-bus seen in the previous clock. They also check that interface selects never overlap an SRAM cycle and that the acknowledge only falls on the second clock of a processor slot. The bench scenarios show the things a property cannot see. Those are the exact word enables that reach the SRAM, spare slots handed to the processor, the second access in one round, late requests that are ignored, and the reset state.

// File: rtl/mra_pkg.sv
package mra_pkg;

  // Kind of access occupying the current slot
  typedef enum logic [1:0] {
    ACC_IDLE    = 2'd0,
    ACC_NET     = 2'd1,
    ACC_CPU_MEM = 2'd2,
    ACC_CPU_NIF = 2'd3
  } acc_e;

  // Slot decision, evaluated on the first clock of a slot
  function automatic acc_e pick_access(input logic own_slot, input logic want,
                                       input logic req, input logic to_nif);
    if (own_slot) begin
      if (!req) return ACC_IDLE;
      return to_nif ? ACC_CPU_NIF : ACC_CPU_MEM;
    end
    if (want) return ACC_NET;
    if (req && !to_nif) return ACC_CPU_MEM;
    return ACC_IDLE;
  endfunction

  function automatic logic is_cpu(input acc_e k);
    return (k == ACC_CPU_MEM) || (k == ACC_CPU_NIF);
  endfunction

  function automatic logic uses_sram(input acc_e k);
    return (k == ACC_NET) || (k == ACC_CPU_MEM);
  endfunction

endpackage

// File: rtl/mra_round_timer.sv
module mra_round_timer #(
  parameter int NUM_SLOTS     = 4,
  parameter int CLKS_PER_SLOT = 2,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int CLK_W  = (CLKS_PER_SLOT > 1) ? $clog2(CLKS_PER_SLOT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot_o,
  output logic              slot_first_o,
  output logic              slot_last_o
);

  localparam logic [CLK_W-1:0]  CLK_LAST  = CLK_W'(CLKS_PER_SLOT - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

  logic [CLK_W-1:0]  clk_cnt_q;
  logic [SLOT_W-1:0] slot_cnt_q;
  logic              clk_wrap;

  assign clk_wrap = (clk_cnt_q == CLK_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_cnt_q  <= '0;
      slot_cnt_q <= '0;
    end else begin
      clk_cnt_q <= clk_wrap ? '0 : clk_cnt_q + 1'b1;
      if (clk_wrap)
        slot_cnt_q <= (slot_cnt_q == SLOT_LAST) ? '0 : slot_cnt_q + 1'b1;
    end
  end

  assign slot_o       = slot_cnt_q;
  assign slot_first_o = (clk_cnt_q == '0);
  assign slot_last_o  = clk_wrap;

  // R2
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_last_o |=> $stable(slot_o));
  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_last_o && slot_o != SLOT_LAST) |=> (slot_o == $past(slot_o) + 1'b1) && slot_first_o);
  // R2
  round_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_last_o && slot_o == SLOT_LAST) |=> (slot_o == '0) && slot_first_o);

endmodule

// File: rtl/mra_slot_decider.sv
module mra_slot_decider
  import mra_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int WE_W      = 2,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              slot_first_i,
  input  logic              want_bus_i,
  input  logic [WE_W-1:0]   net_we_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [WE_W-1:0]   cpu_be_i,
  input  logic              cpu_to_nif_i,
  input  logic [SLOT_W-1:0] cpu_nif_idx_i,
  output acc_e              kind_o,
  output logic [SLOT_W-1:0] dev_o,
  output logic [WE_W-1:0]   wen_o,
  output logic [SLOT_W-1:0] nif_idx_o,
  output logic              nif_wr_o
);

  localparam logic [SLOT_W-1:0] CPU_SLOT = SLOT_W'(NUM_SLOTS - 1);

  acc_e              live_kind, kind_q;
  logic [WE_W-1:0]   live_wen, wen_q;
  logic [SLOT_W-1:0] dev_q, nif_idx_q;
  logic              nif_wr_q;
  logic              own_slot;

  assign own_slot  = (slot_i == CPU_SLOT);
  assign live_kind = pick_access(own_slot, want_bus_i, cpu_req_i, cpu_to_nif_i);

  always_comb begin
    unique case (live_kind)
      ACC_NET:     live_wen = net_we_i;
      ACC_CPU_MEM: live_wen = cpu_we_i ? cpu_be_i : '0;
      default:     live_wen = '0;
    endcase
  end

  // Capture the decision at the end of the first clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q    <= ACC_IDLE;
      wen_q     <= '0;
      dev_q     <= '0;
      nif_idx_q <= '0;
      nif_wr_q  <= 1'b0;
    end else if (slot_first_i) begin
      kind_q    <= live_kind;
      wen_q     <= live_wen;
      dev_q     <= slot_i;
      nif_idx_q <= cpu_nif_idx_i;
      nif_wr_q  <= cpu_we_i;
    end
  end

  assign kind_o    = slot_first_i ? live_kind     : kind_q;
  assign wen_o     = slot_first_i ? live_wen      : wen_q;
  assign dev_o     = slot_first_i ? slot_i        : dev_q;
  assign nif_idx_o = slot_first_i ? cpu_nif_idx_i : nif_idx_q;
  assign nif_wr_o  = slot_first_i ? cpu_we_i      : nif_wr_q;

  // R11
  hold_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_first_i |-> $stable(kind_o) && $stable(wen_o));
  // R4
  late_want_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_first_i && kind_o == ACC_NET) |-> $past(want_bus_i));
  // R6
  own_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_slot |-> kind_o != ACC_NET);

endmodule

// File: rtl/mra_port_driver.sv
module mra_port_driver
  import mra_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int WE_W      = 2,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int NIF_N  = NUM_SLOTS - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slot_first_i,
  input  acc_e                 kind_i,
  input  logic [SLOT_W-1:0]    dev_i,
  input  logic [WE_W-1:0]      wen_i,
  input  logic [SLOT_W-1:0]    nif_idx_i,
  input  logic                 nif_wr_i,
  output logic [NUM_SLOTS-1:0] grant_o,
  output logic                 sram_ce_o,
  output logic [WE_W-1:0]      sram_wen_o,
  output logic [NIF_N-1:0]     nif_sel_o,
  output logic                 nif_wr_o,
  output logic                 cpu_ack_o
);

  logic cpu_owned;
  logic nif_acc;

  assign cpu_owned = rst_n && is_cpu(kind_i);
  assign nif_acc   = rst_n && (kind_i == ACC_CPU_NIF);

  for (genvar i = 0; i < NIF_N; i++) begin : g_net
    assign grant_o[i]   = rst_n && (kind_i == ACC_NET) && (dev_i == SLOT_W'(i));
    assign nif_sel_o[i] = nif_acc && (nif_idx_i == SLOT_W'(i));
  end
  assign grant_o[NUM_SLOTS-1] = cpu_owned;

  assign sram_ce_o  = rst_n && uses_sram(kind_i);
  assign sram_wen_o = sram_ce_o ? wen_i : '0;
  assign nif_wr_o   = nif_acc && nif_wr_i;
  assign cpu_ack_o  = cpu_owned && !slot_first_i;

  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  // R7
  nif_no_sram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nif_sel_o != '0) |-> !sram_ce_o && $onehot(nif_sel_o));
  // R10
  ack_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack_o |-> grant_o[NUM_SLOTS-1] && $past(grant_o[NUM_SLOTS-1]));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o == '0) |-> !sram_ce_o && (sram_wen_o == '0));

endmodule

// File: rtl/mem_round_arbiter.sv
module mem_round_arbiter
  import mra_pkg::*;
#(
  parameter int NUM_SLOTS     = 4,
  parameter int CLKS_PER_SLOT = 2,
  parameter int WE_W          = 2,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int NIF_N  = NUM_SLOTS - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 want_bus,
  input  logic [WE_W-1:0]      net_we,
  input  logic                 cpu_req,
  input  logic                 cpu_we,
  input  logic [WE_W-1:0]      cpu_be,
  input  logic                 cpu_to_nif,
  input  logic [SLOT_W-1:0]    cpu_nif_idx,
  output logic [SLOT_W-1:0]    slot,
  output logic                 slot_first,
  output logic [NUM_SLOTS-1:0] grant,
  output logic                 sram_ce,
  output logic [WE_W-1:0]      sram_wen,
  output logic [NIF_N-1:0]     nif_sel,
  output logic                 nif_wr,
  output logic                 cpu_ack
);

  localparam logic [SLOT_W-1:0] CPU_SLOT = SLOT_W'(NUM_SLOTS - 1);

  logic [SLOT_W-1:0] slot_w;
  logic              first_w, last_w;
  acc_e              kind_w;
  logic [SLOT_W-1:0] dev_w, nif_idx_w;
  logic [WE_W-1:0]   wen_w;
  logic              nif_wr_w;

  mra_round_timer #(.NUM_SLOTS(NUM_SLOTS), .CLKS_PER_SLOT(CLKS_PER_SLOT)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_o       (slot_w),
    .slot_first_o (first_w),
    .slot_last_o  (last_w)
  );

  mra_slot_decider #(.NUM_SLOTS(NUM_SLOTS), .WE_W(WE_W)) u_decide (
    .clk           (clk),
    .rst_n         (rst_n),
    .slot_i        (slot_w),
    .slot_first_i  (first_w),
    .want_bus_i    (want_bus),
    .net_we_i      (net_we),
    .cpu_req_i     (cpu_req),
    .cpu_we_i      (cpu_we),
    .cpu_be_i      (cpu_be),
    .cpu_to_nif_i  (cpu_to_nif),
    .cpu_nif_idx_i (cpu_nif_idx),
    .kind_o        (kind_w),
    .dev_o         (dev_w),
    .wen_o         (wen_w),
    .nif_idx_o     (nif_idx_w),
    .nif_wr_o      (nif_wr_w)
  );

  mra_port_driver #(.NUM_SLOTS(NUM_SLOTS), .WE_W(WE_W)) u_drive (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_first_i (first_w),
    .kind_i       (kind_w),
    .dev_i        (dev_w),
    .wen_i        (wen_w),
    .nif_idx_i    (nif_idx_w),
    .nif_wr_i     (nif_wr_w),
    .grant_o      (grant),
    .sram_ce_o    (sram_ce),
    .sram_wen_o   (sram_wen),
    .nif_sel_o    (nif_sel),
    .nif_wr_o     (nif_wr),
    .cpu_ack_o    (cpu_ack)
  );

  assign slot       = slot_w;
  assign slot_first = rst_n && first_w;

  // R6
  cpu_slot_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_w == CPU_SLOT) |-> (grant[NUM_SLOTS-2:0] == '0));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (grant == '0) && !sram_ce && !cpu_ack && (nif_sel == '0));
  // R2
  last_not_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_w |-> !first_w);

endmodule

// File: tb/mem_round_arbiter_test.sv
module mem_round_arbiter_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       want_bus, cpu_req, cpu_we, cpu_to_nif;
  logic [1:0] net_we, cpu_be, cpu_nif_idx;
  logic [1:0] slot;
  logic       slot_first, sram_ce, nif_wr, cpu_ack;
  logic [3:0] grant;
  logic [1:0] sram_wen;
  logic [2:0] nif_sel;

  always #4 clk = ~clk;

  mem_round_arbiter uut (
    .clk(clk), .rst_n(rst_n), .want_bus(want_bus), .net_we(net_we),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_be(cpu_be),
    .cpu_to_nif(cpu_to_nif), .cpu_nif_idx(cpu_nif_idx),
    .slot(slot), .slot_first(slot_first), .grant(grant), .sram_ce(sram_ce),
    .sram_wen(sram_wen), .nif_sel(nif_sel), .nif_wr(nif_wr), .cpu_ack(cpu_ack)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // Reference state for the current slot: 0 idle, 1 net, 2 cpu mem, 3 cpu nif
  int m_kind, m_dev, m_wen, m_nif, m_nifwr;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int ref_kind(int s, bit want, bit req, bit to_nif);
    if (s == 3) return req ? (to_nif ? 3 : 2) : 0;
    if (want) return 1;
    return (req && !to_nif) ? 2 : 0;
  endfunction

  task automatic set_in(bit w, int nwe, bit rq, bit we, int be, bit nf, int ix);
    want_bus = w; net_we = 2'(nwe); cpu_req = rq; cpu_we = we;
    cpu_be = 2'(be); cpu_to_nif = nf; cpu_nif_idx = 2'(ix);
  endtask

  task automatic set_rand();
    set_in(($urandom % 3) == 0, $urandom % 4, ($urandom % 2) == 0,
           ($urandom % 2) == 0, $urandom % 4, ($urandom % 4) == 0, $urandom % 3);
  endtask

  // Directed inputs for the first two rounds, indexed by clock k
  task automatic set_directed(int k);
    case (k)
      0, 1:   set_in(1, 2'b01, 1, 1, 2'b11, 0, 0);           // R3 in0 write, cpu locked out
      2, 3:   set_in(0, 0, 1, 1, 2'b10, 0, 0);               // R5 spare slot to cpu
      4:      set_in(0, 0, 0, 0, 0, 0, 0);
      5:      set_in(1, 2'b11, 0, 0, 0, 0, 0);               // R4 late want
      6, 7:   set_in(0, 0, 1, 1, 0, 1, 1);                   // R7 nif write idx 1
      8, 9:   set_in(0, 0, 1, 0, 0, 1, 2);                   // R8 nif in spare slot
      10, 11: set_in(1, 2'b10, 1, 1, 2'b01, 0, 0);           // R3 in1
      12, 13: set_in(0, 0, 0, 0, 0, 0, 0);                   // R9 idle
      14:     set_in(1, 2'b11, 1, 0, 2'b11, 0, 0);           // R6 cpu read beats want
      15:     set_in(1, 2'b01, 0, 1, 2'b01, 1, 2);           // R11 inputs change
      default: set_rand();
    endcase
  endtask

  task automatic check_cycle(int k);
    int s, eg, ece, ewen, enif, enwr, eack;
    bit first;
    string tag;
    s = (k / 2) % 4;
    first = (k % 2) == 0;
    chk("R2", "slot", int'(slot), s);
    chk("R2", "slot_first", int'(slot_first), int'(first));
    if (first) begin
      m_kind = ref_kind(s, want_bus, cpu_req, cpu_to_nif);
      m_dev = s;
      m_wen = (m_kind == 1) ? int'(net_we) : (m_kind == 2 && cpu_we) ? int'(cpu_be) : 0;
      m_nif = int'(cpu_nif_idx);
      m_nifwr = int'(cpu_we);
      case (m_kind)
        1: tag = "R3";
        2: tag = (s == 3) ? "R6" : "R5";
        3: tag = "R7";
        default: tag = (s != 3 && cpu_req && cpu_to_nif) ? "R8" : "R9";
      endcase
    end else begin
      tag = (want_bus && s != 3 && m_kind != 1) ? "R4" : "R11";
    end
    eg   = (m_kind == 1) ? (1 << m_dev) : (m_kind >= 2) ? 8 : 0;
    ece  = (m_kind == 1 || m_kind == 2) ? 1 : 0;
    ewen = ece ? m_wen : 0;
    enif = (m_kind == 3) ? (1 << m_nif) : 0;
    enwr = (m_kind == 3) ? m_nifwr : 0;
    eack = (!first && m_kind >= 2) ? 1 : 0;
    chk(tag, "grant", int'(grant), eg);
    chk(tag, "sram_ce", int'(sram_ce), ece);
    chk(tag, "sram_wen", int'(sram_wen), ewen);
    chk(tag, "nif_sel", int'(nif_sel), enif);
    chk(tag, "nif_wr", int'(nif_wr), enwr);
    chk("R10", "cpu_ack", int'(cpu_ack), eack);
  endtask

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0;
    set_rand();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      // R1: everything quiet in reset
      chk("R1", "grant", int'(grant), 0);
      chk("R1", "sram_ce", int'(sram_ce), 0);
      chk("R1", "sram_wen", int'(sram_wen), 0);
      chk("R1", "nif_sel", int'(nif_sel), 0);
      chk("R1", "cpu_ack", int'(cpu_ack), 0);
      chk("R1", "slot_first", int'(slot_first), 0);
      @(posedge clk); #1;
      set_rand();
    end
    rst_n = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      set_directed(k);
      @(negedge clk);
      check_cycle(k);
      @(posedge clk); #1;
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule